// File: doc/BRIEF.md
# Hit Timestamp Unit with Gray-Coded Coarse Counter

This block stamps discriminator hits from eight channels with a coarse arrival time. One free-running counter, kept in reflected binary (Gray) code, is shared by all channels. Each channel's discriminator sends a double pulse per hit. The rising edge of each pulse latches the shared Gray count straight from the channel's own input line, with no relation to the counter clock. Because only one bit of a Gray count changes per step, a latch that lands during a counter transition is off by one count at most.

Each latched word is carried into the counter clock domain through a two-flop synchroniser. It is then converted to plain binary. The two captures of a hit are paired, and the pair is checked for the expected spacing of one or two counts. The result is packed into a 22-bit hit word: channel number in bits 21:19, binary first-capture time in bits 18:3, a pair-valid flag in bit 2, and one phase bit per capture in bits 1 and 0. A phase bit is the LSB of that capture's count. It tells a fine-time stage which slope of its two-count reference period the sample fell on.

Words leave on a valid/ready stream through a single output register. A channel can be masked so that its hits are dropped.

Top module: `hit_timestamp_unit`

## Requirements
- R1: While reset is low, out_valid is 0 and the coarse count is 0. After release the count advances by one at every clock edge, so a pulse that arrives after k edges since release is stamped with time k mod 65536.
- R2: The shared Gray count changes in exactly one bit at every clock edge after reset.
- R3: Bits 18:3 of a hit word carry the first capture's count in plain binary, not in Gray code.
- R4: Bit 2 (pair valid) is 1 exactly when the second capture is 1 or 2 counts after the first, modulo 65536.
- R5: If no second pulse is seen within PAIR_WIN clocks of the first, a word is still emitted, with bit 2 = 0 and bit 0 = 0.
- R6: Bit 1 is the LSB of the first capture's count. Bit 0 is the LSB of the second capture's count.
- R7: While mask bit i is 1, pulses on hit line i produce no word and leave no half-paired state behind.
- R8: When several channels have words waiting at the same time, the lowest channel number is sent first.
- R9: While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_word does not change.
- R10: If a channel completes a hit while its own previous word is still waiting inside the channel, the new hit is discarded.
- R11: A pair that straddles the counter wrap (65534 then 0) is reported as valid, with time 65534.
- R12: Bits 21:19 of a hit word carry the number of the channel that produced it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hit_i | input | 8 | Discriminator lines, one per channel, asynchronous to clk |
| mask_i | input | 8 | Per-channel mask; 1 drops that channel's hits |
| out_valid | output | 1 | Hit word available |
| out_ready | input | 1 | Consumer accepts the word |
| out_word | output | 22 | {channel, binary time, pair valid, phase first, phase second} |

## Verification
The bench drives pulse pairs spaced 1, 2, 3 and 4 counts apart, as well as lone pulses. This separates the pair-valid decision from the timeout path and shows that both phase bits follow their own capture. Simultaneous hits on two channels with the consumer stalled show whether arbitration picks by channel number or by luck. Three back-to-back hits on one channel show where a word is dropped rather than overwritten. Masked channels and a pair that crosses the counter wrap cover the edge cases.

// File: rtl/tsu_pkg.sv
package tsu_pkg;
  localparam int TSU_NUM_CH   = 8;
  localparam int TSU_CNT_W    = 16;
  localparam int TSU_PAIR_WIN = 8;

  typedef enum logic {
    PAIR_IDLE = 1'b0,
    PAIR_WAIT = 1'b1
  } pair_st_t;
endpackage

// File: rtl/tsu_gray_ctr.sv
module tsu_gray_ctr #(
  parameter int CNT_W = tsu_pkg::TSU_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [CNT_W-1:0] gray_o
);
  function automatic logic [CNT_W-1:0] bin_to_gray(input logic [CNT_W-1:0] b);
    return b ^ (b >> 1);
  endfunction

  logic [CNT_W-1:0] bin_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bin_q  <= '0;
      gray_o <= '0;
    end else begin
      bin_q  <= bin_q + 1'b1;
      gray_o <= bin_to_gray(bin_q + 1'b1);
    end
  end
endmodule

// File: rtl/tsu_channel.sv
module tsu_channel
  import tsu_pkg::*;
#(
  parameter int CNT_W    = tsu_pkg::TSU_CNT_W,
  parameter int CH_W     = 3,
  parameter int IDX      = 0,
  parameter int PAIR_WIN = tsu_pkg::TSU_PAIR_WIN,
  localparam int WORD_W  = CH_W + CNT_W + 3,
  localparam int WC_W    = $clog2(PAIR_WIN) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hit_i,
  input  logic              mask_i,
  input  logic [CNT_W-1:0]  gray_i,
  input  logic              take_i,
  output logic              pend_o,
  output logic              fin_o,
  output logic [WORD_W-1:0] word_o
);
  function automatic logic [CNT_W-1:0] gray_to_bin(input logic [CNT_W-1:0] g);
    logic [CNT_W-1:0] b;
    b[CNT_W-1] = g[CNT_W-1];
    for (int i = CNT_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  function automatic logic spacing_ok(input logic [CNT_W-1:0] d);
    return (d == CNT_W'(1)) || (d == CNT_W'(2));
  endfunction

  // capture side, clocked by the hit line itself
  logic             slot_q, tog_a_q, tog_b_q;
  logic [CNT_W-1:0] cap_a_q, cap_b_q;

  always_ff @(posedge hit_i or negedge rst_n) begin
    if (!rst_n) begin
      slot_q  <= 1'b0;
      tog_a_q <= 1'b0;
      tog_b_q <= 1'b0;
      cap_a_q <= '0;
      cap_b_q <= '0;
    end else begin
      slot_q <= ~slot_q;
      if (!slot_q) begin
        cap_a_q <= gray_i;
        tog_a_q <= ~tog_a_q;
      end else begin
        cap_b_q <= gray_i;
        tog_b_q <= ~tog_b_q;
      end
    end
  end

  // two-flop synchroniser plus edge history
  logic [2:0]       sa_q, sb_q;
  logic [CNT_W-1:0] ga1_q, ga2_q, gb1_q, gb2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sa_q  <= '0;
      sb_q  <= '0;
      ga1_q <= '0;
      ga2_q <= '0;
      gb1_q <= '0;
      gb2_q <= '0;
    end else begin
      sa_q  <= {sa_q[1:0], tog_a_q};
      sb_q  <= {sb_q[1:0], tog_b_q};
      ga1_q <= cap_a_q;
      ga2_q <= ga1_q;
      gb1_q <= cap_b_q;
      gb2_q <= gb1_q;
    end
  end

  logic             evt_a, evt_b, evt_ok;
  logic [CNT_W-1:0] cap_bin, gap;

  assign evt_a   = sa_q[1] ^ sa_q[2];
  assign evt_b   = sb_q[1] ^ sb_q[2];
  assign evt_ok  = (evt_a | evt_b) & ~mask_i;
  assign cap_bin = gray_to_bin(evt_a ? ga2_q : gb2_q);

  // pairing
  pair_st_t         st_q;
  logic [CNT_W-1:0] t1_q;
  logic [WC_W-1:0]  wcnt_q;
  logic             done_pair, done_to;
  logic [WORD_W-1:0] word_d;

  assign gap       = cap_bin - t1_q;
  assign done_pair = (st_q == PAIR_WAIT) && evt_ok;
  assign done_to   = (st_q == PAIR_WAIT) && !evt_ok && (wcnt_q == WC_W'(PAIR_WIN - 1));
  assign fin_o     = done_pair | done_to;

  always_comb begin
    word_d = {CH_W'(IDX), t1_q, 1'b0, t1_q[0], 1'b0};
    if (done_pair) word_d = {CH_W'(IDX), t1_q, spacing_ok(gap), t1_q[0], cap_bin[0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= PAIR_IDLE;
      t1_q   <= '0;
      wcnt_q <= '0;
      pend_o <= 1'b0;
      word_o <= '0;
    end else begin
      case (st_q)
        PAIR_IDLE: begin
          wcnt_q <= '0;
          if (evt_ok) begin
            st_q <= PAIR_WAIT;
            t1_q <= cap_bin;
          end
        end
        default: begin
          wcnt_q <= wcnt_q + 1'b1;
          if (fin_o || ((evt_a | evt_b) && mask_i)) st_q <= PAIR_IDLE;
        end
      endcase
      if (fin_o && !pend_o) begin
        pend_o <= 1'b1;
        word_o <= word_d;
      end else if (take_i) begin
        pend_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/tsu_pick.sv
module tsu_pick #(
  parameter int NUM_CH = tsu_pkg::TSU_NUM_CH
) (
  input  logic [NUM_CH-1:0] pend_i,
  output logic [NUM_CH-1:0] grant_o
);
  always_comb begin
    logic found;
    found   = 1'b0;
    grant_o = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (pend_i[i] && !found) begin
        grant_o[i] = 1'b1;
        found      = 1'b1;
      end
    end
  end
endmodule

// File: rtl/hit_timestamp_unit.sv
module hit_timestamp_unit #(
  parameter int NUM_CH   = tsu_pkg::TSU_NUM_CH,
  parameter int CNT_W    = tsu_pkg::TSU_CNT_W,
  parameter int PAIR_WIN = tsu_pkg::TSU_PAIR_WIN,
  localparam int CH_W    = $clog2(NUM_CH),
  localparam int WORD_W  = CH_W + CNT_W + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] hit_i,
  input  logic [NUM_CH-1:0] mask_i,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_word
);
  logic [CNT_W-1:0]  gray;
  logic [NUM_CH-1:0] pend, grant, take, fin;
  logic [WORD_W-1:0] words [NUM_CH];
  logic [WORD_W-1:0] sel_word;
  logic              load;

  tsu_gray_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk    (clk),
    .rst_n  (rst_n),
    .gray_o (gray)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    tsu_channel #(
      .CNT_W    (CNT_W),
      .CH_W     (CH_W),
      .IDX      (i),
      .PAIR_WIN (PAIR_WIN)
    ) u_ch (
      .clk    (clk),
      .rst_n  (rst_n),
      .hit_i  (hit_i[i]),
      .mask_i (mask_i[i]),
      .gray_i (gray),
      .take_i (take[i]),
      .pend_o (pend[i]),
      .fin_o  (fin[i]),
      .word_o (words[i])
    );
  end

  tsu_pick #(.NUM_CH(NUM_CH)) u_pick (
    .pend_i  (pend),
    .grant_o (grant)
  );

  assign load = (|pend) && (!out_valid || out_ready);
  assign take = grant & {NUM_CH{load}};

  always_comb begin
    sel_word = '0;
    for (int i = 0; i < NUM_CH; i++) if (grant[i]) sel_word = sel_word | words[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_word  <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_word  <= sel_word;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/tsu_checker.sv
module tsu_checker #(
  parameter int NUM_CH = 8,
  parameter int CNT_W  = 16,
  parameter int WORD_W = 22
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CNT_W-1:0]  gray,
  input logic [NUM_CH-1:0] pend,
  input logic [NUM_CH-1:0] grant,
  input logic [NUM_CH-1:0] take,
  input logic              out_valid,
  input logic              out_ready,
  input logic [WORD_W-1:0] out_word
);
  p_gray_one_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $countones(gray ^ $past(gray)) == 1);

  p_grant_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  p_grant_lowest_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (grant != '0) |-> (((grant - NUM_CH'(1)) & pend) == '0));

  p_hold_out_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_word)));

  p_pend_kept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(pend & ~take) & ~pend) == '0));
endmodule

bind hit_timestamp_unit tsu_checker #(
  .NUM_CH (NUM_CH),
  .CNT_W  (CNT_W),
  .WORD_W (WORD_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .gray      (gray),
  .pend      (pend),
  .grant     (grant),
  .take      (take),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_word  (out_word)
);

// File: tb/hit_timestamp_unit_tb.sv
module hit_timestamp_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  hit = '0;
  logic [7:0]  mask = '0;
  logic        out_ready = 1'b1;
  logic        out_valid;
  logic [21:0] out_word;

  int checks = 0;
  int fails = 0;
  int k = 0;
  bit ended = 0;
  logic [21:0] exp_q[$];

  always #5 clk = ~clk;

  hit_timestamp_unit u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .hit_i     (hit),
    .mask_i    (mask),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_word  (out_word)
  );

  // reference count of edges since reset release (R1)
  always @(posedge clk) k <= rst_n ? k + 1 : 0;

  function automatic logic [21:0] expect_word(int ch, int k0, int d);
    int t1, t2;
    logic ok, pb;
    t1 = k0 % 65536;
    t2 = (k0 + d) % 65536;
    ok = (d == 1) || (d == 2);
    pb = (d > 0) ? t2[0] : 1'b0;
    return {ch[2:0], t1[15:0], ok, t1[0], pb};
  endfunction

  task automatic check(bit cond, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!cond) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!ended) begin
      ended = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  // scoreboard: every accepted word compared with the model queue
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        check(0, "R7/R10 unexpected word", 32'(out_word), 32'h0);
      end else begin
        logic [21:0] e;
        e = exp_q.pop_front();
        check(out_word == e, "R3/R4/R5/R6/R12 word", 32'(out_word), 32'(e));
      end
    end
  end

  task automatic fire(logic [7:0] sel, int d, output int k0);
    @(posedge clk);
    #3;
    k0 = k;
    hit = hit | sel;
    #3;
    hit = hit & ~sel;
    if (d > 0) begin
      repeat (d) @(posedge clk);
      #3;
      hit = hit | sel;
      #3;
      hit = hit & ~sel;
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    report();
  end

  initial begin
    int k0;
    logic [21:0] held;
    repeat (4) @(posedge clk);
    #1;
    check(out_valid == 1'b0, "R1 reset valid", 32'(out_valid), 32'h0);
    @(posedge clk);
    #2;
    rst_n = 1'b1;
    idle(3);
    check(out_valid == 1'b0, "R1 idle after reset", 32'(out_valid), 32'h0);

    // R3 R4 R6 R12: spacings 1..4
    fire(8'h01, 1, k0); exp_q.push_back(expect_word(0, k0, 1)); idle(20);
    fire(8'h02, 2, k0); exp_q.push_back(expect_word(1, k0, 2)); idle(20);
    fire(8'h10, 3, k0); exp_q.push_back(expect_word(4, k0, 3)); idle(20);
    fire(8'h40, 4, k0); exp_q.push_back(expect_word(6, k0, 4)); idle(20);
    // R5: lone pulse times out
    fire(8'h80, 0, k0); exp_q.push_back(expect_word(7, k0, 0)); idle(30);
    check(exp_q.size() == 0, "R5 all emitted", 32'(exp_q.size()), 32'h0);

    // R7: masked channel produces nothing, then recovers unmasked
    mask = 8'h08;
    idle(2);
    fire(8'h08, 1, k0); idle(20);
    check(out_valid == 1'b0, "R7 masked no word", 32'(out_valid), 32'h0);
    mask = 8'h00;
    idle(2);
    fire(8'h08, 2, k0); exp_q.push_back(expect_word(3, k0, 2)); idle(20);
    check(exp_q.size() == 0, "R7 unmasked pair", 32'(exp_q.size()), 32'h0);

    // R8 R9: simultaneous channels 2 and 5, consumer stalled
    out_ready = 1'b0;
    fire(8'h24, 1, k0);
    exp_q.push_back(expect_word(2, k0, 1));
    exp_q.push_back(expect_word(5, k0, 1));
    idle(15);
    @(negedge clk);
    check(out_valid == 1'b1, "R9 valid while stalled", 32'(out_valid), 32'h1);
    check(out_word[21:19] == 3'd2, "R8 lowest first", 32'(out_word[21:19]), 32'h2);
    held = out_word;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(out_valid && out_word == held, "R9 word held", 32'(out_word), 32'(held));
    end
    @(posedge clk); #2;
    out_ready = 1'b1;
    idle(10);
    check(exp_q.size() == 0, "R8 both drained", 32'(exp_q.size()), 32'h0);

    // R10: third hit on a channel with a word still waiting is dropped
    out_ready = 1'b0;
    fire(8'h08, 1, k0); exp_q.push_back(expect_word(3, k0, 1)); idle(15);
    fire(8'h08, 2, k0); exp_q.push_back(expect_word(3, k0, 2)); idle(15);
    fire(8'h08, 1, k0); idle(15);
    out_ready = 1'b1;
    idle(15);
    check(exp_q.size() == 0, "R10 two words", 32'(exp_q.size()), 32'h0);
    check(out_valid == 1'b0, "R10 third dropped", 32'(out_valid), 32'h0);

    // R11: pair across the wrap
    forever begin
      @(posedge clk);
      #1;
      if (k == 65533) break;
    end
    fire(8'h01, 2, k0);
    check(k0 == 65534, "R11 setup", 32'(k0), 32'd65534);
    exp_q.push_back(expect_word(0, k0, 2));
    idle(20);
    check(exp_q.size() == 0, "R11 wrap pair", 32'(exp_q.size()), 32'h0);

    report();
  end
endmodule